// File: doc/BRIEF.md
# Multichannel framed byte transmitter

This block produces, for each of several channels, a stream of bytes with a control-character flag, one byte per byte clock, to feed an 8B/10B encoder. Each frame opens with a programmable run of one to three control characters and closes with a second, separately programmed run. Between the two runs the payload flows from a FIFO-style 32-bit read port with a valid/ready handshake, one byte at a time.

Successive frames on a channel are kept apart by an exact, per-channel count of fill characters. The fill character has a programmable value and is also sent whenever the channel has nothing else to send. Channels marked for synchronized start wait at a common barrier and leave it on the same byte clock. Configuration is written through a small per-channel register port. Encoding, serialization, clocking and host transfers are handled elsewhere.

Top module: `mfb_tx_top`

## Requirements
- R1: Register 1 of a channel sets the opening run: characters at bits [7:0], [15:8] and [23:16] are sent in that order, the number sent is the count in bits [25:24], a count of 0 sends one, and every one of them carries the control flag.
- R2: Register 2 sets the closing run with the same field layout and count rule as R1, and the closing run starts on the byte clock right after the last payload byte.
- R3: Register 3 holds the frame length in 32-bit words; a value of 0 sends one word.
- R4: Register 0 bits [15:8] hold the fill character (0xBC after reset); it is sent with the control flag set while idle, while waiting at the barrier, in the gap and during underrun, and register 4 gives the exact number of fill characters between the last closing character and the next opening character.
- R5: Payload bytes carry a clear control flag and leave least-significant byte first; a word is taken when pl_valid and pl_ready are both high, and pl_ready is high only at a word boundary inside the payload.
- R6: Register 0 bit 0 enables the channel; frames repeat back to back while it is set, and once it is cleared the channel finishes its frame and then sends only fill characters.
- R7: Channels with register 0 bit 1 set wait before each frame until every channel with that bit set is waiting, then all of them send their first opening character on the same byte clock; a channel with the bit set but not enabled holds the others back.
- R8: A payload word missing at a word boundary inserts fill characters without ending the frame and sets a sticky underrun flag, which a write to register 0 of that channel clears; a new underrun in the same cycle wins over the clear.
- R9: After reset every channel sends the fill character 0xBC with the control flag set, pl_ready is low and underrun is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | CH_W | Channel selected by the write |
| cfg_addr | input | 3 | Register index within the channel |
| cfg_wdata | input | 32 | Register write data |
| pl_data | input | NUM_CH*32 | Payload word per channel |
| pl_valid | input | NUM_CH | Payload word present per channel |
| pl_ready | output | NUM_CH | Payload word taken per channel |
| tx_byte | output | NUM_CH*8 | Byte sent per channel |
| tx_k | output | NUM_CH | Control-character flag per channel |
| underrun | output | NUM_CH | Sticky payload underrun per channel |

## Verification
The bench builds the block with two channels, which is the smallest setup in which the start barrier has a partner to wait for. On one channel it sweeps every opening and closing count code (including 0), frame lengths 0 to 3 and gaps 0 to 2, and it checks each resulting stream byte by byte against a sequence it computes from those numbers. The second channel, with its own fill value and lengths, is used to show the barrier holding and then releasing both channels together. Starving the payload port in mid-frame brings the underrun, its clear and the resumed frame within reach.

// File: rtl/mfb_pkg.sv
package mfb_pkg;

    localparam int LEN_W   = 16;
    localparam int GAP_W   = 16;
    localparam int SEQ_N   = 3;
    localparam logic [7:0] FILL_RST = 8'hBC;
    localparam logic [7:0] SOF_RST  = 8'hFB;
    localparam logic [7:0] EOF_RST  = 8'hFD;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_SYNC,
        ST_START,
        ST_PAYLOAD,
        ST_END,
        ST_GAP
    } fr_state_t;

    typedef enum logic [2:0] {
        RA_CTRL = 3'd0,
        RA_SOF  = 3'd1,
        RA_EOF  = 3'd2,
        RA_LEN  = 3'd3,
        RA_GAP  = 3'd4
    } reg_addr_t;

    typedef struct packed {
        logic [1:0]             cnt;
        logic [SEQ_N-1:0][7:0]  k;
    } kseq_t;

    typedef struct packed {
        logic             en;
        logic             sync;
        logic [7:0]       fill;
        kseq_t            sof;
        kseq_t            eof;
        logic [LEN_W-1:0] words;
        logic [GAP_W-1:0] gap;
    } chan_cfg_t;

    function automatic kseq_t unpack_seq(input logic [31:0] w);
        kseq_t s;
        s.k   = w[SEQ_N*8-1:0];
        s.cnt = w[25:24];
        return s;
    endfunction

    function automatic logic [1:0] seq_last(input logic [1:0] cnt);
        return (cnt == 2'd0) ? 2'd0 : cnt - 2'd1;
    endfunction

    function automatic logic [LEN_W-1:0] words_last(input logic [LEN_W-1:0] n);
        return (n == '0) ? '0 : n - 1'b1;
    endfunction

    function automatic chan_cfg_t cfg_reset();
        chan_cfg_t c;
        c.en    = 1'b0;
        c.sync  = 1'b0;
        c.fill  = FILL_RST;
        c.sof   = '{cnt: 2'd1, k: {SEQ_N{SOF_RST}}};
        c.eof   = '{cnt: 2'd1, k: {SEQ_N{EOF_RST}}};
        c.words = LEN_W'(1);
        c.gap   = '0;
        return c;
    endfunction

endpackage

// File: rtl/mfb_cfg_regs.sv
module mfb_cfg_regs
    import mfb_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [CH_W-1:0] ch,
    input  logic [2:0]  addr,
    input  logic [31:0] wdata,
    output chan_cfg_t   cfg      [NUM_CH],
    output logic [NUM_CH-1:0] clr_stat
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic hit;
        assign hit         = we && (ch == CH_W'(i));
        assign clr_stat[i] = hit && (addr == RA_CTRL);

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[i] <= cfg_reset();
            end else if (hit) begin
                case (addr)
                    RA_CTRL: begin
                        cfg[i].en   <= wdata[0];
                        cfg[i].sync <= wdata[1];
                        cfg[i].fill <= wdata[15:8];
                    end
                    RA_SOF:  cfg[i].sof   <= unpack_seq(wdata);
                    RA_EOF:  cfg[i].eof   <= unpack_seq(wdata);
                    RA_LEN:  cfg[i].words <= wdata[LEN_W-1:0];
                    RA_GAP:  cfg[i].gap   <= wdata[GAP_W-1:0];
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/mfb_sync_barrier.sv
module mfb_sync_barrier #(
    parameter int NUM_CH = 4
) (
    input  logic [NUM_CH-1:0] armed,
    input  logic [NUM_CH-1:0] waiting,
    output logic              go
);

    logic [NUM_CH-1:0] blocking;

    always_comb begin
        blocking = armed & ~waiting;
        go       = (|armed) && (blocking == '0);
    end

endmodule

// File: rtl/mfb_chan.sv
module mfb_chan
    import mfb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  chan_cfg_t   cfg,
    input  logic        clr_stat,
    input  logic        go,
    input  logic [31:0] pl_data,
    input  logic        pl_valid,
    output logic        pl_ready,
    output logic [7:0]  tx_byte,
    output logic        tx_k,
    output logic        underrun,
    output logic        waiting
);

    fr_state_t        st;
    fr_state_t        after_gap;
    logic [1:0]       seq_idx;
    logic [1:0]       byte_idx;
    logic [LEN_W-1:0] word_idx;
    logic [GAP_W-1:0] gap_idx;
    logic [23:0]      hold;
    logic             take;
    logic             gap_done;

    assign pl_ready = (st == ST_PAYLOAD) && (byte_idx == 2'd0);
    assign take     = pl_ready && pl_valid;
    assign waiting  = (st == ST_WAIT_SYNC);
    assign gap_done = ((GAP_W+1)'(gap_idx) + 1'b1) >= (GAP_W+1)'(cfg.gap);

    always_comb begin
        if (!cfg.en)       after_gap = ST_IDLE;
        else if (cfg.sync) after_gap = ST_WAIT_SYNC;
        else               after_gap = ST_START;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            seq_idx  <= '0;
            byte_idx <= '0;
            word_idx <= '0;
            gap_idx  <= '0;
            hold     <= '0;
            tx_byte  <= FILL_RST;
            tx_k     <= 1'b1;
            underrun <= 1'b0;
        end else begin
            tx_byte <= cfg.fill;
            tx_k    <= 1'b1;
            if (clr_stat) underrun <= 1'b0;
            case (st)
                ST_IDLE: begin
                    seq_idx <= '0;
                    if (cfg.en) st <= cfg.sync ? ST_WAIT_SYNC : ST_START;
                end
                ST_WAIT_SYNC: begin
                    seq_idx <= '0;
                    if (!cfg.en)  st <= ST_IDLE;
                    else if (go)  st <= ST_START;
                end
                ST_START: begin
                    tx_byte <= cfg.sof.k[seq_idx];
                    if (seq_idx >= seq_last(cfg.sof.cnt)) begin
                        st       <= ST_PAYLOAD;
                        byte_idx <= '0;
                        word_idx <= '0;
                    end else begin
                        seq_idx <= seq_idx + 1'b1;
                    end
                end
                ST_PAYLOAD: begin
                    if (byte_idx == 2'd0) begin
                        if (pl_valid) begin
                            tx_byte  <= pl_data[7:0];
                            tx_k     <= 1'b0;
                            hold     <= pl_data[31:8];
                            byte_idx <= 2'd1;
                        end else begin
                            underrun <= 1'b1;
                        end
                    end else begin
                        tx_byte  <= hold[7:0];
                        tx_k     <= 1'b0;
                        hold     <= {8'h00, hold[23:8]};
                        byte_idx <= byte_idx + 1'b1;
                        if (byte_idx == 2'd3) begin
                            if (word_idx >= words_last(cfg.words)) begin
                                st      <= ST_END;
                                seq_idx <= '0;
                            end else begin
                                word_idx <= word_idx + 1'b1;
                            end
                        end
                    end
                end
                ST_END: begin
                    tx_byte <= cfg.eof.k[seq_idx];
                    if (seq_idx >= seq_last(cfg.eof.cnt)) begin
                        seq_idx <= '0;
                        gap_idx <= '0;
                        st      <= (cfg.gap == '0) ? after_gap : ST_GAP;
                    end else begin
                        seq_idx <= seq_idx + 1'b1;
                    end
                end
                ST_GAP: begin
                    seq_idx <= '0;
                    if (gap_done) st <= after_gap;
                    else          gap_idx <= gap_idx + 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_PAYLOAD_LSB_FIRST: assert property (@(posedge clk) disable iff (rst)
        take |=> (!tx_k && tx_byte == $past(pl_data[7:0]))); // R5
    AST_START_IS_K: assert property (@(posedge clk) disable iff (rst)
        (st == ST_START) |=> tx_k); // R1
    AST_END_IS_K: assert property (@(posedge clk) disable iff (rst)
        (st == ST_END) |=> tx_k); // R2
    AST_GAP_FILL: assert property (@(posedge clk) disable iff (rst)
        (st == ST_GAP) |=> (tx_k && tx_byte == $past(cfg.fill))); // R4
    AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (rst)
        (pl_ready && !pl_valid) |=> underrun); // R8
    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        (underrun && !clr_stat) |=> underrun); // R8
    AST_BARRIER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (waiting && cfg.en && !go) |=> waiting); // R7

endmodule

// File: rtl/mfb_tx_top.sv
module mfb_tx_top
    import mfb_pkg::*;
#(
    parameter  int NUM_CH = 4,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [CH_W-1:0]      cfg_ch,
    input  logic [2:0]           cfg_addr,
    input  logic [31:0]          cfg_wdata,
    input  logic [NUM_CH*32-1:0] pl_data,
    input  logic [NUM_CH-1:0]    pl_valid,
    output logic [NUM_CH-1:0]    pl_ready,
    output logic [NUM_CH*8-1:0]  tx_byte,
    output logic [NUM_CH-1:0]    tx_k,
    output logic [NUM_CH-1:0]    underrun
);

    chan_cfg_t         cfg_q [NUM_CH];
    logic [NUM_CH-1:0] clr_stat;
    logic [NUM_CH-1:0] armed;
    logic [NUM_CH-1:0] waiting;
    logic              go;

    mfb_cfg_regs #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .ch       (cfg_ch),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .cfg      (cfg_q),
        .clr_stat (clr_stat)
    );

    mfb_sync_barrier #(.NUM_CH(NUM_CH)) u_barrier (
        .armed   (armed),
        .waiting (waiting),
        .go      (go)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        assign armed[i] = cfg_q[i].sync;

        mfb_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .cfg      (cfg_q[i]),
            .clr_stat (clr_stat[i]),
            .go       (go),
            .pl_data  (pl_data[i*32 +: 32]),
            .pl_valid (pl_valid[i]),
            .pl_ready (pl_ready[i]),
            .tx_byte  (tx_byte[i*8 +: 8]),
            .tx_k     (tx_k[i]),
            .underrun (underrun[i]),
            .waiting  (waiting[i])
        );
    end

endmodule

// File: tb/mfb_tx_top_tb.sv
module mfb_tx_top_tb;

    localparam int NCH = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [0:0]        cfg_ch = '0;
    logic [2:0]        cfg_addr = '0;
    logic [31:0]       cfg_wdata = '0;
    logic [NCH*32-1:0] pl_data;
    logic [NCH-1:0]    pl_valid = '1;
    logic [NCH-1:0]    pl_ready;
    logic [NCH*8-1:0]  tx_byte;
    logic [NCH-1:0]    tx_k;
    logic [NCH-1:0]    underrun;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    mfb_tx_top #(.NUM_CH(NCH)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .pl_data(pl_data),
        .pl_valid(pl_valid), .pl_ready(pl_ready), .tx_byte(tx_byte),
        .tx_k(tx_k), .underrun(underrun)
    );

    // payload source: word w of a channel carries bytes 4w..4w+3
    logic [15:0]    wcnt [NCH];
    logic [NCH-1:0] wclr = '1;

    always @(posedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (wclr[c])                          wcnt[c] <= '0;
            else if (pl_valid[c] && pl_ready[c])  wcnt[c] <= wcnt[c] + 16'd1;
        end
    end

    always_comb begin
        for (int c = 0; c < NCH; c++)
            for (int b = 0; b < 4; b++)
                pl_data[c*32 + b*8 +: 8] = 8'(32'(wcnt[c]) * 4 + b);
    end

    // capture of channel 0 and start-time monitor
    bit         cap_on = 1'b0;
    logic [8:0] cap [0:127];
    int         cap_n = 0;
    longint     cyc = 0;
    bit         mon_on = 1'b0;
    longint     first [NCH];

    always @(negedge clk) begin
        cyc++;
        if (cap_on && cap_n < 128) begin
            cap[cap_n] = {tx_k[0], tx_byte[7:0]};
            cap_n++;
        end
        if (mon_on)
            for (int c = 0; c < NCH; c++)
                if (first[c] < 0 && tx_k[c] && tx_byte[c*8 +: 8] == 8'hF7)
                    first[c] = cyc;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int ch, input int addr, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 1'(ch); cfg_addr = 3'(addr); cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // one sweep point on channel 0: R1 R2 R3 R4 R5 R6
    task automatic run_cfg(input int sc, input int ec, input int fl, input int gl);
        logic [8:0] ex [0:31];
        logic [7:0] sk [3];
        logic [7:0] ek [3];
        int n, p, s, e, f;
        bit ok;
        logic [8:0] a, x;
        sk = '{8'hF7, 8'hFB, 8'hFD};
        ek = '{8'hFE, 8'hFC, 8'h7C};
        s = (sc == 0) ? 1 : sc;
        e = (ec == 0) ? 1 : ec;
        f = (fl == 0) ? 1 : fl;
        wr(0, 0, 32'h0000_BC00);
        idle_wait(40);
        wclr[0] = 1'b1; idle_wait(1); wclr[0] = 1'b0;
        wr(0, 1, {6'd0, 2'(sc), sk[2], sk[1], sk[0]});
        wr(0, 2, {6'd0, 2'(ec), ek[2], ek[1], ek[0]});
        wr(0, 3, 32'(fl));
        wr(0, 4, 32'(gl));
        cap_n = 0; cap_on = 1'b1;
        wr(0, 0, 32'h0000_BC01);
        idle_wait(50);
        cap_on = 1'b0;
        n = 0;
        for (int i = 0; i < s; i++)     begin ex[n] = {1'b1, sk[i]}; n++; end
        for (int i = 0; i < f*4; i++)   begin ex[n] = {1'b0, 8'(i)}; n++; end
        for (int i = 0; i < e; i++)     begin ex[n] = {1'b1, ek[i]}; n++; end
        for (int i = 0; i < gl; i++)    begin ex[n] = {1'b1, 8'hBC}; n++; end
        ex[n] = {1'b1, sk[0]}; n++;
        p = 0;
        while (p < cap_n && cap[p] == {1'b1, 8'hBC}) p++;
        ok = 1'b1; a = '0; x = '0;
        for (int i = 0; i < n; i++) begin
            if (p + i >= cap_n) begin ok = 1'b0; a = 9'h1FF; x = ex[i]; break; end
            if (cap[p+i] != ex[i]) begin ok = 1'b0; a = cap[p+i]; x = ex[i]; break; end
        end
        chk(ok, $sformatf("R1 R2 R3 R4 R5 R6 sof=%0d eof=%0d len=%0d gap=%0d", sc, ec, fl, gl),
            longint'(a), longint'(x));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
        $finish;
    end

    initial begin
        int p;
        bit ok;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        wclr = '0;
        @(negedge clk);
        // R9 reset state
        chk(tx_k == '1 && tx_byte == {NCH{8'hBC}}, "R9 fill after reset",
            longint'({tx_k, tx_byte}), longint'({2'b11, 16'hBCBC}));
        chk(pl_ready == '0 && underrun == '0, "R9 ready and underrun low",
            longint'({pl_ready, underrun}), 0);

        // sweep of sequence counts, lengths and gaps
        for (int sc = 0; sc < 4; sc++)
            for (int ec = 0; ec < 4; ec++)
                for (int fl = 0; fl < 4; fl++)
                    for (int gl = 0; gl < 3; gl++)
                        run_cfg(sc, ec, fl, gl);

        // R8 underrun in mid-frame
        wr(0, 0, 32'h0000_BC00);
        idle_wait(40);
        wclr[0] = 1'b1; idle_wait(1); wclr[0] = 1'b0;
        wr(0, 1, {6'd0, 2'd1, 24'h00_00F7});
        wr(0, 2, {6'd0, 2'd1, 24'h00_00FE});
        wr(0, 3, 32'd2);
        wr(0, 4, 32'd3);
        wr(0, 0, 32'h0000_BC00);
        pl_valid[0] = 1'b0;
        cap_n = 0; cap_on = 1'b1;
        wr(0, 0, 32'h0000_BC01);
        idle_wait(12);
        chk(underrun[0] == 1'b1, "R8 underrun flag set", underrun[0], 1);
        pl_valid[0] = 1'b1;
        idle_wait(30);
        cap_on = 1'b0;
        p = 0;
        while (p < cap_n && cap[p] == {1'b1, 8'hBC}) p++;
        ok = (p < cap_n) && cap[p] == {1'b1, 8'hF7};
        p++;
        while (p < cap_n && cap[p] == {1'b1, 8'hBC}) p++;
        for (int i = 0; i < 8; i++)
            if (p + i >= cap_n || cap[p+i] != {1'b0, 8'(i)}) ok = 1'b0;
        if (p + 8 >= cap_n || cap[p+8] != {1'b1, 8'hFE}) ok = 1'b0;
        chk(ok, "R8 frame resumes after fill", p, 0);
        wr(0, 0, 32'h0000_BC00);
        chk(underrun[0] == 1'b0, "R8 control write clears flag", underrun[0], 0);

        // R6 disabled channel sends only fill
        idle_wait(40);
        cap_n = 0; cap_on = 1'b1;
        idle_wait(20);
        cap_on = 1'b0;
        ok = 1'b1;
        for (int i = 0; i < cap_n; i++) if (cap[i] != {1'b1, 8'hBC}) ok = 1'b0;
        chk(ok, "R6 fill only after disable", cap_n, 20);

        // R7 start barrier across both channels
        wr(0, 1, {6'd0, 2'd3, 24'hFD_FBF7});
        wr(0, 3, 32'd2);
        wr(0, 4, 32'd1);
        wr(1, 1, {6'd0, 2'd2, 24'h00_00F7});
        wr(1, 3, 32'd1);
        wr(1, 4, 32'd5);
        wr(1, 0, 32'h0000_1C02);
        for (int c = 0; c < NCH; c++) first[c] = -1;
        mon_on = 1'b1;
        wr(0, 0, 32'h0000_BC03);
        idle_wait(30);
        chk(first[0] < 0, "R7 enabled channel held at barrier", first[0], -1);
        chk(tx_k[1] && tx_byte[15:8] == 8'h1C, "R4 programmed fill value",
            longint'({tx_k[1], tx_byte[15:8]}), longint'({1'b1, 8'h1C}));
        wr(1, 0, 32'h0000_1C03);
        idle_wait(30);
        chk(first[0] >= 0 && first[0] == first[1], "R7 channels start together",
            first[0], first[1]);
        mon_on = 1'b0;

        report();
        $finish;
    end

endmodule